// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers sixteen numbered interrupt sources and two trap events and decides which one the processor services next. Each numbered source has a pending bit, set on a rising edge of its request line, and an enable bit. A third per-source bit sends the source to a fast transfer path with its own vector table. The controller presents a service request with a 16-bit vector address and a flag that tells the processor which path was chosen. When the processor acknowledges, the served pending bit or trap flag clears on the same edge.

Two trap inputs bypass arbitration entirely. The non-maskable source, number 15, outranks every other numbered source, ignores its enable bit and never takes the fast path. Any fast-path source beats every ordinary source, whatever their numbers. The serial receive and transmit flags either merge into source 6 or split onto sources 9 and 8, depending on whether source 6 is enabled.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the pending, enable and fast-path registers read zero and `irq_req` is low.
- R2: A pending bit is set by a 0-to-1 transition of its request line. A request line held high does not set the bit again after it has been cleared.
- R3: Vector addresses are computed as follows. An ordinary source n below 8 vectors to 2000h+2n. An ordinary source n from 8 upward vectors to 2030h+2(n-8), so source 15 vectors to 203Eh. A fast-path source n (0..14) vectors to 2040h+2n with `irq_pts` high. Source 15 never takes the fast path, even if its fast-path bit is set.
- R4: A captured unimplemented-opcode trap vectors to 2012h and a captured software trap vectors to 2010h, with `irq_trap` high. Both traps win over every numbered source and ignore the enable bits. When both traps are held, the unimplemented-opcode trap is served first.
- R5: A numbered source 0..14 is requested only when its pending and enable bits are both 1. Source 15 is requested whenever it is pending.
- R6: Source 15 wins over all other numbered sources. After it, any pending and enabled source whose fast-path bit is set wins over every source whose fast-path bit is clear.
- R7: Within the fast-path class, and within the ordinary class, the higher-numbered candidate wins.
- R8: With enable bit 6 set, a rising edge of either serial flag sets pending bit 6. With enable bit 6 clear, a rising receive flag sets pending bit 9 and a rising transmit flag sets pending bit 8.
- R9: `svc_ack` while `irq_req` is high clears, at that clock edge, the pending bit or trap flag that was being presented.
- R10: Register access uses `reg_sel` as follows: 0 selects pending, 1 selects enable, 2 selects fast-path, and 3 reads zero and ignores writes. A write replaces the register, but a source edge in the same cycle still sets its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 16 | Request lines of sources 0..15 (rising edge sets pending) |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| trap_unimpl | input | 1 | Unimplemented-opcode trap (rising edge captured) |
| trap_soft | input | 1 | Software trap (rising edge captured) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 pending, 1 enable, 2 fast-path, 3 none |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_sel` |
| svc_ack | input | 1 | Processor accepts the presented interrupt |
| irq_req | output | 1 | An interrupt or trap awaits service |
| irq_vec | output | 16 | Vector address of the presented interrupt |
| irq_pts | output | 1 | Presented interrupt uses the fast-path table |
| irq_trap | output | 1 | Presented event is a trap |

## Verification
The bench builds the block with its default parameters: sixteen sources, a low vector bank of eight entries, and serial sources at positions 6, 8 and 9. With these values every vector formula, including the bank split at source 8 and the 203Eh slot of the non-maskable source, can be reached through register writes alone. Random pending, enable and fast-path patterns written through the register port exercise the class ordering and the number ordering against a bench model. Directed pulses then cover edge capture, trap precedence, the serial merge and split, and the same-cycle race between a write and an edge.

// File: rtl/irq_pkg.sv
// Package: shared types of the interrupt controller.
package irq_pkg;

    // Register select encoding of the software access port.
    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_MASK = 2'd1,
        SEL_PSEL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Class of the arbitration winner, highest rank first in the arbiter.
    typedef enum logic [2:0] {
        WIN_NONE = 3'd0,
        WIN_TRAP = 3'd1,
        WIN_NMI  = 3'd2,
        WIN_PTS  = 3'd3,
        WIN_STD  = 3'd4
    } win_class_e;

endpackage

// File: rtl/irq_edge_route.sv
// Module: irq_edge_route
// Turns request lines into one-cycle set pulses on their rising edges.
// Routes the serial receive and transmit flags onto the merged source or
// the split sources, depending on the merged source's enable bit.
// Assumes all inputs are synchronous to clk.
module irq_edge_route #(
    parameter int NUM_SRC = 16,
    parameter int SER_CMB = 6,
    parameter int SER_TX  = 8,
    parameter int SER_RX  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               ser_rx_flag,
    input  logic               ser_tx_flag,
    input  logic [1:0]         trap_in,
    input  logic               cmb_enable,
    output logic [NUM_SRC-1:0] set_vec,
    output logic [1:0]         trap_rise
);

    logic [NUM_SRC-1:0] src_prev;
    logic [1:0]         trap_prev;
    logic               rx_prev;
    logic               tx_prev;
    logic               rx_rise;
    logic               tx_rise;

    // Remember last-cycle levels of every monitored line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_prev  <= '0;
            trap_prev <= '0;
            rx_prev   <= 1'b0;
            tx_prev   <= 1'b0;
        end else begin
            src_prev  <= src_req;
            trap_prev <= trap_in;
            rx_prev   <= ser_rx_flag;
            tx_prev   <= ser_tx_flag;
        end
    end

    assign rx_rise   = ser_rx_flag & ~rx_prev;
    assign tx_rise   = ser_tx_flag & ~tx_prev;
    assign trap_rise = trap_in & ~trap_prev;

    // Build set pulses per source, folding in the serial routing.
    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_set
            if (i == SER_CMB) begin : g_cmb
                assign set_vec[i] = (src_req[i] & ~src_prev[i])
                                  | (cmb_enable & (rx_rise | tx_rise));
            end else if (i == SER_RX) begin : g_rx
                assign set_vec[i] = (src_req[i] & ~src_prev[i])
                                  | (~cmb_enable & rx_rise);
            end else if (i == SER_TX) begin : g_tx
                assign set_vec[i] = (src_req[i] & ~src_prev[i])
                                  | (~cmb_enable & tx_rise);
            end else begin : g_plain
                assign set_vec[i] = src_req[i] & ~src_prev[i];
            end
        end
    endgenerate

endmodule

// File: rtl/irq_state_regs.sv
// Module: irq_state_regs
// Holds the pending, enable, fast-path and trap flag registers.
// Serves the software access port. Edge sets take precedence over
// writes and acknowledge clears in the same cycle.
// Assumes set and clear vectors are single-cycle pulses.
module irq_state_regs
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] clr_vec,
    input  logic [1:0]         trap_rise,
    input  logic [1:0]         trap_clr,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] psel_q,
    output logic [1:0]         trap_q
);

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] pend_base;
    logic               wr_pend;
    logic               wr_mask;
    logic               wr_psel;

    assign sel     = reg_sel_e'(reg_sel);
    assign wr_pend = reg_wr && (sel == SEL_PEND);
    assign wr_mask = reg_wr && (sel == SEL_MASK);
    assign wr_psel = reg_wr && (sel == SEL_PSEL);

    // Pick the pending value before clears and sets are applied.
    always_comb begin
        pend_base = wr_pend ? reg_wdata : pend_q;
    end

    // Update all controller state each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '0;
            psel_q <= '0;
            trap_q <= '0;
        end else begin
            pend_q <= (pend_base & ~clr_vec) | set_vec;
            if (wr_mask) mask_q <= reg_wdata;
            if (wr_psel) psel_q <= reg_wdata;
            trap_q <= (trap_q & ~trap_clr) | trap_rise;
        end
    end

    // Return the selected register on the read port.
    always_comb begin
        unique case (sel)
            SEL_PEND: reg_rdata = pend_q;
            SEL_MASK: reg_rdata = mask_q;
            SEL_PSEL: reg_rdata = psel_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_arbiter.sv
// Module: irq_arbiter
// Chooses the interrupt to present. Order: traps (unimplemented first),
// the non-maskable top source, fast-path class, ordinary class. Within
// a class the highest number wins. Purely combinational.
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 16,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int NMI    = NUM_SRC - 1
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    input  logic [NUM_SRC-1:0] psel,
    input  logic [1:0]         trap,
    output win_class_e         win_class,
    output logic [IDX_W-1:0]   win_idx,
    output logic               win_soft
);

    logic [NUM_SRC-1:0] nmi_bit;
    logic [NUM_SRC-1:0] pts_cand;
    logic [NUM_SRC-1:0] std_cand;
    logic [IDX_W-1:0]   pts_idx;
    logic [IDX_W-1:0]   std_idx;

    assign nmi_bit  = NUM_SRC'(1) << NMI;
    assign pts_cand = pend & mask & psel & ~nmi_bit;
    assign std_cand = pend & mask & ~psel & ~nmi_bit;

    // Highest-numbered fast-path candidate (later match overrides).
    always_comb begin
        pts_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pts_cand[i]) pts_idx = IDX_W'(i);
        end
    end

    // Highest-numbered ordinary candidate.
    always_comb begin
        std_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (std_cand[i]) std_idx = IDX_W'(i);
        end
    end

    // Rank the classes and select the winner.
    always_comb begin
        win_class = WIN_NONE;
        win_idx   = '0;
        win_soft  = 1'b0;
        if (trap != 2'b00) begin
            win_class = WIN_TRAP;
            win_soft  = ~trap[0];
        end else if (pend[NMI]) begin
            win_class = WIN_NMI;
            win_idx   = IDX_W'(NMI);
        end else if (pts_cand != '0) begin
            win_class = WIN_PTS;
            win_idx   = pts_idx;
        end else if (std_cand != '0) begin
            win_class = WIN_STD;
            win_idx   = std_idx;
        end
    end

endmodule

// File: rtl/irq_vector_map.sv
// Module: irq_vector_map
// Converts the winner class and number into a vector address.
// The ordinary table is split into a low bank and a high bank.
// The fast-path table is one contiguous bank. Entries are 2 bytes apart.
module irq_vector_map
    import irq_pkg::*;
#(
    parameter int          NUM_SRC     = 16,
    parameter int          VEC_W       = 16,
    parameter int          LO_CNT      = 8,
    parameter logic [15:0] LO_BASE     = 16'h2000,
    parameter logic [15:0] HI_BASE     = 16'h2030,
    parameter logic [15:0] PTS_BASE    = 16'h2040,
    parameter logic [15:0] VEC_UNIMPL  = 16'h2012,
    parameter logic [15:0] VEC_SOFT    = 16'h2010,
    localparam int         IDX_W       = $clog2(NUM_SRC)
) (
    input  win_class_e       win_class,
    input  logic [IDX_W-1:0] win_idx,
    input  logic             win_soft,
    output logic [VEC_W-1:0] vec
);

    logic [VEC_W-1:0] off_n;
    logic [VEC_W-1:0] off_hi;
    logic [IDX_W-1:0] hi_idx;

    assign hi_idx = win_idx - IDX_W'(LO_CNT);
    assign off_n  = VEC_W'({win_idx, 1'b0});
    assign off_hi = VEC_W'({hi_idx, 1'b0});

    // Form the vector address for the winning event.
    always_comb begin
        unique case (win_class)
            WIN_TRAP: vec = win_soft ? VEC_W'(VEC_SOFT) : VEC_W'(VEC_UNIMPL);
            WIN_PTS:  vec = VEC_W'(PTS_BASE) + off_n;
            WIN_NMI, WIN_STD:
                vec = (int'(win_idx) < LO_CNT) ? VEC_W'(LO_BASE) + off_n
                                               : VEC_W'(HI_BASE) + off_hi;
            default:  vec = '0;
        endcase
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: irq_vector_ctrl (top)
// Prioritized vectored interrupt controller. Captures source edges,
// holds pending/enable/fast-path state, arbitrates and presents a vector.
// An acknowledge clears the presented event. Outputs are combinational
// from registered state. svc_ack is honoured only while irq_req is high.
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int          NUM_SRC    = 16,
    parameter int          VEC_W      = 16,
    parameter int          LO_CNT     = 8,
    parameter int          SER_CMB    = 6,
    parameter int          SER_TX     = 8,
    parameter int          SER_RX     = 9,
    parameter logic [15:0] LO_BASE    = 16'h2000,
    parameter logic [15:0] HI_BASE    = 16'h2030,
    parameter logic [15:0] PTS_BASE   = 16'h2040,
    parameter logic [15:0] VEC_UNIMPL = 16'h2012,
    parameter logic [15:0] VEC_SOFT   = 16'h2010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               ser_rx_flag,
    input  logic               ser_tx_flag,
    input  logic               trap_unimpl,
    input  logic               trap_soft,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    input  logic               svc_ack,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic               irq_pts,
    output logic               irq_trap
);

    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [1:0]         trap_rise;
    logic [1:0]         trap_clr;
    logic [NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0] mask_w;
    logic [NUM_SRC-1:0] psel_w;
    logic [1:0]         trap_w;
    win_class_e         win_class;
    logic [IDX_W-1:0]   win_idx;
    logic               win_soft;
    logic               take;

    irq_edge_route #(
        .NUM_SRC(NUM_SRC), .SER_CMB(SER_CMB), .SER_TX(SER_TX), .SER_RX(SER_RX)
    ) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_req    (src_req),
        .ser_rx_flag(ser_rx_flag),
        .ser_tx_flag(ser_tx_flag),
        .trap_in    ({trap_soft, trap_unimpl}),
        .cmb_enable (mask_w[SER_CMB]),
        .set_vec    (set_vec),
        .trap_rise  (trap_rise)
    );

    irq_state_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .trap_rise(trap_rise),
        .trap_clr (trap_clr),
        .reg_wr   (reg_wr),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .pend_q   (pend_w),
        .mask_q   (mask_w),
        .psel_q   (psel_w),
        .trap_q   (trap_w)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .pend     (pend_w),
        .mask     (mask_w),
        .psel     (psel_w),
        .trap     (trap_w),
        .win_class(win_class),
        .win_idx  (win_idx),
        .win_soft (win_soft)
    );

    irq_vector_map #(
        .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .LO_CNT(LO_CNT),
        .LO_BASE(LO_BASE), .HI_BASE(HI_BASE), .PTS_BASE(PTS_BASE),
        .VEC_UNIMPL(VEC_UNIMPL), .VEC_SOFT(VEC_SOFT)
    ) u_map (
        .win_class(win_class),
        .win_idx  (win_idx),
        .win_soft (win_soft),
        .vec      (irq_vec)
    );

    assign irq_req  = (win_class != WIN_NONE);
    assign irq_trap = (win_class == WIN_TRAP);
    assign irq_pts  = (win_class == WIN_PTS);
    assign take     = svc_ack && irq_req;

    // Translate an acknowledge into a clear of the served event.
    always_comb begin
        clr_vec  = '0;
        trap_clr = 2'b00;
        if (take) begin
            if (win_class == WIN_TRAP) begin
                trap_clr = win_soft ? 2'b10 : 2'b01;
            end else begin
                clr_vec = NUM_SRC'(1) << win_idx;
            end
        end
    end

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
// Module: irq_vector_ctrl_chk
// Assertion checker for irq_vector_ctrl, attached by bind below.
module irq_vector_ctrl_chk #(
    parameter int          NUM_SRC    = 16,
    parameter int          VEC_W      = 16,
    parameter logic [15:0] PTS_BASE   = 16'h2040,
    parameter logic [15:0] VEC_UNIMPL = 16'h2012
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] mask,
    input logic [NUM_SRC-1:0] psel,
    input logic [1:0]         trap,
    input logic               irq_req,
    input logic [VEC_W-1:0]   irq_vec,
    input logic               irq_pts,
    input logic               irq_trap
);

    localparam int NMI = NUM_SRC - 1;
    localparam logic [NUM_SRC-1:0] LOW_BITS = {1'b0, {(NUM_SRC-1){1'b1}}};

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && mask == '0 && psel == '0 && !irq_req)); // R1

    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (trap != 2'b00 || pend[NMI] || (pend & mask & LOW_BITS) != '0)); // R5

    AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        trap[0] |-> (irq_trap && irq_vec == VEC_W'(VEC_UNIMPL))); // R4

    AST_PTS_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (trap == 2'b00 && !pend[NMI] && (pend & mask & psel & LOW_BITS) != '0)
            |-> irq_pts); // R6

    AST_PTS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pts |-> (irq_vec >= VEC_W'(PTS_BASE)
                     && irq_vec < VEC_W'(PTS_BASE) + VEC_W'(2 * (NUM_SRC - 1)))); // R3

    AST_VEC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[0] == 1'b0)); // R3

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .PTS_BASE(PTS_BASE), .VEC_UNIMPL(VEC_UNIMPL)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pend_w),
    .mask    (mask_w),
    .psel    (psel_w),
    .trap    (trap_w),
    .irq_req (irq_req),
    .irq_vec (irq_vec),
    .irq_pts (irq_pts),
    .irq_trap(irq_trap)
);

// File: tb/sim_irq_vector_ctrl.sv
// Bench for irq_vector_ctrl: random register patterns plus directed cases.
module sim_irq_vector_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_req = '0;
    logic        ser_rx_flag = 1'b0;
    logic        ser_tx_flag = 1'b0;
    logic        trap_unimpl = 1'b0;
    logic        trap_soft = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        svc_ack = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic        irq_pts;
    logic        irq_trap;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
        .trap_unimpl(trap_unimpl), .trap_soft(trap_soft),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .svc_ack(svc_ack), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_pts(irq_pts), .irq_trap(irq_trap)
    );

    // Model: returns {req, pts, trap, vec} from the requirement text.
    function automatic logic [18:0] model(input logic [15:0] p, input logic [15:0] m,
                                          input logic [15:0] s, input logic [1:0] t);
        logic [15:0] pc = p & m & s & 16'h7FFF;
        logic [15:0] sc = p & m & ~s & 16'h7FFF;
        if (t[0]) return {3'b101, 16'h2012};
        if (t[1]) return {3'b101, 16'h2010};
        if (p[15]) return {3'b100, 16'h203E};
        for (int i = 14; i >= 0; i--)
            if (pc[i]) return {3'b110, 16'(16'h2040 + 2 * i)};
        for (int i = 14; i >= 0; i--)
            if (sc[i]) return {3'b100, (i < 8) ? 16'(16'h2000 + 2 * i)
                                               : 16'(16'h2030 + 2 * (i - 8))};
        return '0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] d);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic ack();
        @(negedge clk);
        svc_ack = 1'b1;
        @(negedge clk);
        svc_ack = 1'b0;
    endtask

    task automatic pulse_src(input int n);
        @(negedge clk); src_req[n] = 1'b1;
        @(negedge clk); src_req[n] = 1'b0;
    endtask

    task automatic check_out(input string req, input logic [18:0] exp);
        #1 check(req, {13'd0, irq_req, irq_pts, irq_trap, irq_vec}, {13'd0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 200000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] d, p, m, s;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, d); check("R1 pend", {16'd0, d}, 0);
        rd(2'd1, d); check("R1 mask", {16'd0, d}, 0);
        rd(2'd2, d); check("R1 psel", {16'd0, d}, 0);
        check_out("R1 outputs", '0);

        // R10: select 3 reads zero and a write there changes nothing
        wr(2'd3, 16'hFFFF);
        rd(2'd3, d); check("R10 sel3 read", {16'd0, d}, 0);
        rd(2'd1, d); check("R10 sel3 write ignored", {16'd0, d}, 0);
        check_out("R10 sel3 no request", '0);

        // R2/R9: edge sets pending, ack clears, held level does not re-set
        wr(2'd1, 16'h0010);
        @(negedge clk); src_req[4] = 1'b1;
        @(negedge clk);
        rd(2'd0, d); check("R2 edge sets pend4", {16'd0, d}, 32'h0010);
        check_out("R3 vector source 4", {3'b100, 16'h2008});
        ack();
        repeat (2) @(negedge clk);
        rd(2'd0, d); check("R2 R9 held level after ack", {16'd0, d}, 0);
        check_out("R9 request gone", '0);
        src_req[4] = 1'b0;

        // R5: pending but disabled source is not requested
        pulse_src(3);
        rd(2'd0, d); check("R5 pend3 set", {16'd0, d}, 32'h0008);
        check_out("R5 masked source silent", '0);
        wr(2'd0, 16'h0000);

        // R3/R5: source 15 unmaskable, never fast path
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'hFFFF);
        wr(2'd0, 16'h8000);
        check_out("R5 R3 nmi vector", {3'b100, 16'h203E});
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'h0000);

        // R4: traps outrank everything and ignore enables, unimpl first
        wr(2'd0, 16'h8000);
        @(negedge clk); trap_unimpl = 1'b1; trap_soft = 1'b1;
        @(negedge clk); trap_unimpl = 1'b0; trap_soft = 1'b0;
        check_out("R4 unimpl first", {3'b101, 16'h2012});
        ack();
        check_out("R4 R9 soft next", {3'b101, 16'h2010});
        ack();
        check_out("R4 R9 back to nmi", {3'b100, 16'h203E});
        ack();
        check_out("R9 nmi cleared", '0);

        // R8: merged serial routing with enable bit 6 set
        wr(2'd1, 16'h0040);
        @(negedge clk); ser_rx_flag = 1'b1;
        @(negedge clk); ser_rx_flag = 1'b0;
        rd(2'd0, d); check("R8 merged rx", {16'd0, d}, 32'h0040);
        check_out("R8 merged vector", {3'b100, 16'h200C});
        wr(2'd0, 16'h0000);

        // R8: split routing with bit 6 clear, 8 and 9 enabled
        wr(2'd1, 16'h0300);
        @(negedge clk); ser_rx_flag = 1'b1;
        @(negedge clk); ser_rx_flag = 1'b0;
        rd(2'd0, d); check("R8 split rx to 9", {16'd0, d}, 32'h0200);
        check_out("R8 split rx vector", {3'b100, 16'h2032});
        wr(2'd0, 16'h0000);
        @(negedge clk); ser_tx_flag = 1'b1;
        @(negedge clk); ser_tx_flag = 1'b0;
        rd(2'd0, d); check("R8 split tx to 8", {16'd0, d}, 32'h0100);
        wr(2'd0, 16'h0000);

        // R6/R7: fast-path low number beats ordinary high number
        wr(2'd1, 16'hFFFF);
        wr(2'd2, 16'h0006);
        wr(2'd0, 16'h1006);
        check_out("R6 R7 pts 2 wins", {3'b110, 16'h2044});
        ack();
        check_out("R6 R9 pts 1 next", {3'b110, 16'h2042});
        ack();
        check_out("R7 std 12 last", {3'b100, 16'h2038});
        wr(2'd0, 16'h0000);

        // R10: same-cycle write clear loses to an edge
        @(negedge clk);
        src_req[2] = 1'b1; reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 16'h0000;
        @(negedge clk);
        reg_wr = 1'b0; src_req[2] = 1'b0;
        rd(2'd0, d); check("R10 edge beats write", {16'd0, d}, 32'h0004);
        wr(2'd0, 16'h0000);

        // R3 R5 R6 R7 R10: random register patterns against the model
        for (int k = 0; k < 300; k++) begin
            p = 16'($urandom);
            m = 16'($urandom);
            s = 16'($urandom) & 16'($urandom);
            wr(2'd1, m);
            wr(2'd2, s);
            wr(2'd0, p);
            rd(2'd0, d); check("R10 pend readback", {16'd0, d}, {16'd0, p});
            check_out("R6 R7 random arbitration", model(p, m, s, 2'b00));
        end

        finish_run();
    end

endmodule